// File: doc/BRIEF.md
# Event Staging Dual-Clock FIFO

This block moves event data words from a front-end link clocked by a local 40.00 MHz oscillator into a processing domain clocked at 40.08 MHz. Every word is tagged with an end-of-event bit. The read side runs slightly faster than the write side, so it would catch up with the writer in the middle of an event and read an empty store. To avoid this, it does not start an event until a small number of that event's words are present. After that it streams the event on back-to-back read cycles.

The storage is a dual-clock RAM. The write and read pointers cross between the domains in gray code through two-stage synchronizers. A count of stored end tags also crosses to the read side. An event that is already complete in the store, such as a one-word event, is released without waiting for the pre-fill count. Two sticky flags, both visible in the read domain, report a stream that ran dry and a write that was dropped because the store was full.

Top module: `evt_stage_fifo`

## Requirements
- R1: Each accepted word appears once on `rd_data_o`, in write order. `rd_last_o` is 1 exactly on words that were written with `wr_last_i` = 1.
- R2: The first word of an event is not read until at least PREFILL (default 2) words of that event have been written, unless the event's end-tagged word has already been written.
- R3: Once an event has started and the writer supplies its words on consecutive write cycles, `rd_valid_o` stays high on consecutive read cycles until the end-tagged word. This holds for events of up to 500 words.
- R4: A complete event shorter than PREFILL (a single end-tagged word) is delivered without waiting for any later event's words.
- R5: `rd_valid_o` is asserted only for words that are actually stored. Nothing is read from an empty store.
- R6: If the store is empty while an event is being streamed, no read happens and `underrun_o` rises. `underrun_o` stays at 1 until reset, and the event resumes when words arrive.
- R7: A word offered while all 2^ADDR_W (default 1024) entries are occupied is discarded, and the stored words are not changed. `overflow_o` then rises in the read domain and stays at 1 until reset.
- R8: While `rst_ni` is low, `rd_valid_o`, `underrun_o` and `overflow_o` are 0.
- R9: The pointers that cross between the clock domains change by at most one bit per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Link-side write clock |
| rd_clk_i | input | 1 | Processing-side read clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| wr_valid_i | input | 1 | Write strobe for one word |
| wr_data_i | input | DATA_W | Word to store |
| wr_last_i | input | 1 | Marks the final word of an event |
| rd_valid_o | output | 1 | Output word valid this read cycle |
| rd_data_o | output | DATA_W | Output word |
| rd_last_o | output | 1 | Output word ends its event |
| underrun_o | output | 1 | Sticky: stream found the store empty mid-event |
| overflow_o | output | 1 | Sticky: a write was dropped because the store was full |

## Verification
The hardest state to reach from the ports is a full store, because the reader is faster than the writer and drains continuously. The bench stops the read clock while the line is idle, writes a 1024-word event followed by one extra end-tagged word, and then restarts the reader. A scoreboard then shows that the extra word never appears and that the full event arrives intact. The bench reaches an underrun by pausing the writer just before an event's final word, and it checks the pre-fill gate by leaving a long pause after the first word of an event.

// File: rtl/evt_stage_pkg.sv
package evt_stage_pkg;
  typedef enum logic {
    RS_WAIT   = 1'b0,
    RS_STREAM = 1'b1
  } rd_state_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/evt_dpram.sv
module evt_dpram #(
  parameter int W      = 33,
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wr_clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [W-1:0]      rd_data_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  // head word visible in the same cycle so the end tag steers the pop decision
  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/evt_wr_ctrl.sv
module evt_wr_ctrl #(
  parameter int ADDR_W = 10,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              wr_clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic              wr_last_i,
  input  logic [PTR_W-1:0]  rgray_sync_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [PTR_W-1:0]  wgray_o,
  output logic [PTR_W-1:0]  eot_gray_o,
  output logic              full_o,
  output logic              ovf_o
);
  logic [PTR_W-1:0] wbin_q, wbin_nxt, wgray_q;
  logic [PTR_W-1:0] eot_bin_q, eot_bin_nxt, eot_gray_q;
  logic             eot_inc_q, ovf_q;

  assign full_o   = (wgray_q == {~rgray_sync_i[PTR_W-1:PTR_W-2], rgray_sync_i[PTR_W-3:0]});
  assign wr_en_o  = wr_valid_i & ~full_o;
  assign wbin_nxt = wbin_q + PTR_W'(wr_en_o);
  assign eot_bin_nxt = eot_bin_q + PTR_W'(eot_inc_q);

  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q     <= '0;
      wgray_q    <= '0;
      eot_inc_q  <= 1'b0;
      eot_bin_q  <= '0;
      eot_gray_q <= '0;
      ovf_q      <= 1'b0;
    end else begin
      wbin_q     <= wbin_nxt;
      wgray_q    <= wbin_nxt ^ (wbin_nxt >> 1);
      // tag count trails the pointer by one cycle, so the data is never behind it
      eot_inc_q  <= wr_en_o & wr_last_i;
      eot_bin_q  <= eot_bin_nxt;
      eot_gray_q <= eot_bin_nxt ^ (eot_bin_nxt >> 1);
      if (wr_valid_i && full_o) ovf_q <= 1'b1;
    end
  end

  assign wr_addr_o  = wbin_q[ADDR_W-1:0];
  assign wgray_o    = wgray_q;
  assign eot_gray_o = eot_gray_q;
  assign ovf_o      = ovf_q;
endmodule

// File: rtl/evt_rd_ctrl.sv
module evt_rd_ctrl
  import evt_stage_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int PREFILL = 2,
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic [PTR_W-1:0]  wgray_sync_i,
  input  logic [PTR_W-1:0]  eot_gray_sync_i,
  input  logic              head_last_i,
  output logic              pop_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [PTR_W-1:0]  rgray_o,
  output logic              in_evt_o,
  output logic [PTR_W-1:0]  fill_o,
  output logic              eot_pend_o,
  output logic              underrun_o
);
  rd_state_e        state_q;
  logic [PTR_W-1:0] wbin, eot_wbin, fill;
  logic [PTR_W-1:0] rbin_q, rbin_nxt, rgray_q, eot_rbin_q;
  logic             empty, eot_pend, start_ok, pop, urun_q;

  always_comb begin
    for (int i = 0; i < PTR_W; i++) begin
      wbin[i]     = ^(wgray_sync_i >> i);
      eot_wbin[i] = ^(eot_gray_sync_i >> i);
    end
  end

  assign fill     = wbin - rbin_q;
  assign empty    = (fill == '0);
  assign eot_pend = (eot_wbin != eot_rbin_q);
  assign start_ok = !empty && ((fill >= PTR_W'(PREFILL)) || eot_pend);
  assign pop      = (state_q == RS_STREAM) ? !empty : start_ok;
  assign rbin_nxt = rbin_q + PTR_W'(pop);

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RS_WAIT;
      rbin_q     <= '0;
      rgray_q    <= '0;
      eot_rbin_q <= '0;
      urun_q     <= 1'b0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
      if (pop) begin
        state_q <= head_last_i ? RS_WAIT : RS_STREAM;
        if (head_last_i) eot_rbin_q <= eot_rbin_q + 1'b1;
      end
      if (state_q == RS_STREAM && empty) urun_q <= 1'b1;
    end
  end

  assign pop_o      = pop;
  assign rd_addr_o  = rbin_q[ADDR_W-1:0];
  assign rgray_o    = rgray_q;
  assign in_evt_o   = (state_q == RS_STREAM);
  assign fill_o     = fill;
  assign eot_pend_o = eot_pend;
  assign underrun_o = urun_q;
endmodule

// File: rtl/evt_stage_fifo.sv
module evt_stage_fifo
  import evt_stage_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 10,
  parameter int PREFILL = 2
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_last_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o,
  output logic              underrun_o,
  output logic              overflow_o
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int WORD_W = DATA_W + 1;

  logic              wr_en, wr_full, ovf_w, ovf_rsync;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PTR_W-1:0]  wgray, eot_gray, rgray;
  logic [PTR_W-1:0]  rgray_wsync, wgray_rsync, eot_rsync;
  logic              rd_pop, in_evt, eot_pend;
  logic [PTR_W-1:0]  rd_fill;
  logic [WORD_W-1:0] head;

  evt_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .wr_clk_i, .rst_ni, .wr_valid_i, .wr_last_i,
    .rgray_sync_i(rgray_wsync),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wgray_o(wgray),
    .eot_gray_o(eot_gray), .full_o(wr_full), .ovf_o(ovf_w)
  );

  evt_dpram #(.W(WORD_W), .ADDR_W(ADDR_W)) u_ram (
    .wr_clk_i, .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i({wr_last_i, wr_data_i}),
    .rd_addr_i(rd_addr), .rd_data_o(head)
  );

  evt_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk_i(wr_clk_i), .rst_ni, .d_i(rgray), .q_o(rgray_wsync)
  );
  evt_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk_i(rd_clk_i), .rst_ni, .d_i(wgray), .q_o(wgray_rsync)
  );
  evt_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_eot (
    .clk_i(rd_clk_i), .rst_ni, .d_i(eot_gray), .q_o(eot_rsync)
  );
  evt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ovf (
    .clk_i(rd_clk_i), .rst_ni, .d_i(ovf_w), .q_o(ovf_rsync)
  );

  evt_rd_ctrl #(.ADDR_W(ADDR_W), .PREFILL(PREFILL)) u_rd (
    .rd_clk_i, .rst_ni,
    .wgray_sync_i(wgray_rsync), .eot_gray_sync_i(eot_rsync),
    .head_last_i(head[WORD_W-1]),
    .pop_o(rd_pop), .rd_addr_o(rd_addr), .rgray_o(rgray),
    .in_evt_o(in_evt), .fill_o(rd_fill), .eot_pend_o(eot_pend),
    .underrun_o(underrun_o)
  );

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      rd_last_o  <= 1'b0;
    end else begin
      rd_valid_o <= rd_pop;
      if (rd_pop) begin
        rd_data_o <= head[DATA_W-1:0];
        rd_last_o <= head[WORD_W-1];
      end
    end
  end

  assign overflow_o = ovf_rsync;
endmodule

// File: rtl/evt_stage_fifo_chk.sv
module evt_stage_fifo_chk #(
  parameter int ADDR_W  = 10,
  parameter int PREFILL = 2,
  localparam int PTR_W  = ADDR_W + 1
) (
  input logic             wr_clk_i,
  input logic             rd_clk_i,
  input logic             rst_ni,
  input logic             wr_valid_i,
  input logic             wr_full,
  input logic [PTR_W-1:0] wgray,
  input logic [PTR_W-1:0] rgray,
  input logic             rd_pop,
  input logic [PTR_W-1:0] rd_fill,
  input logic             eot_pend,
  input logic             in_evt,
  input logic             rd_valid_o,
  input logic             underrun_o,
  input logic             overflow_o
);
  // R5
  no_empty_read_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_pop |-> (rd_fill != '0));

  // R5
  valid_from_pop_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_pop));

  // R2
  start_gate_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_pop && !in_evt) |-> ((rd_fill >= PTR_W'(PREFILL)) || eot_pend));

  // R6
  underrun_sticky_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);

  // R7
  overflow_sticky_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  // R7
  full_drop_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wr_full && wr_valid_i) |=> $stable(wgray));

  // R9
  wptr_gray_step_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R9
  rptr_gray_step_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind evt_stage_fifo evt_stage_fifo_chk #(.ADDR_W(ADDR_W), .PREFILL(PREFILL)) u_chk (
  .wr_clk_i(wr_clk_i), .rd_clk_i(rd_clk_i), .rst_ni(rst_ni),
  .wr_valid_i(wr_valid_i), .wr_full(wr_full), .wgray(wgray), .rgray(rgray),
  .rd_pop(rd_pop), .rd_fill(rd_fill), .eot_pend(eot_pend), .in_evt(in_evt),
  .rd_valid_o(rd_valid_o), .underrun_o(underrun_o), .overflow_o(overflow_o)
);

// File: tb/evt_stage_fifo_bench.sv
`timescale 1ns/1ps
module evt_stage_fifo_bench;
  logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0, rd_run = 1'b1;
  logic        wr_valid = 1'b0, wr_last = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_valid, rd_last, underrun, overflow;
  logic [31:0] rd_data;

  int checks = 0, errs = 0;
  bit finished = 0;
  logic [32:0] exp_q [$];
  int  ev_wr_cnt [64];
  bit  ev_done   [64];
  bit  ev_gap_ok [64];
  int  ev_len    [64];
  int  wr_ev = 0;

  always #10 wr_clk = ~wr_clk;
  always begin
    #9.98;
    if (rd_run) rd_clk = ~rd_clk;
  end

  evt_stage_fifo u_evt_stage_fifo (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_last_i(wr_last),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_last_o(rd_last),
    .underrun_o(underrun), .overflow_o(overflow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_event(input int len, input int first_gap, input int stall,
                            input int gap_after, input bit gap_ok);
    int idx;
    idx = wr_ev;
    wr_ev++;
    ev_len[idx]    = len;
    ev_gap_ok[idx] = gap_ok;
    for (int i = 0; i < len; i++) begin
      @(negedge wr_clk);
      wr_valid = 1'b1;
      wr_data  = {idx[11:0], i[19:0]};
      wr_last  = (i == len - 1);
      exp_q.push_back({wr_last, wr_data});
      @(posedge wr_clk);
      ev_wr_cnt[idx]++;
      if (i == len - 1) ev_done[idx] = 1'b1;
      if ((i == 0 && first_gap > 0 && len > 1) || (i == len - 2 && stall > 0)) begin
        @(negedge wr_clk);
        wr_valid = 1'b0;
        repeat ((i == 0 ? first_gap : stall) - 1) @(negedge wr_clk);
      end
    end
    @(negedge wr_clk);
    wr_valid = 1'b0;
    wr_last  = 1'b0;
    repeat (gap_after) @(negedge wr_clk);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (20) @(posedge wr_clk);
  endtask

  // scoreboard monitor
  initial begin
    int  mon_ev = 0;
    bit  mon_in = 0;
    int  gaps = 0;
    logic [32:0] e;
    forever begin
      @(negedge rd_clk);
      if (!rst_n) continue;
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "word with nothing stored", {31'd0, rd_last, rd_data}, 64'd0);
        end else begin
          e = exp_q.pop_front();
          // R1 order and tag; data crossing relies on gray pointers (R9)
          chk({rd_last, rd_data} == e, "R1", "word/tag", {31'd0, rd_last, rd_data}, {31'd0, e});
          if (!mon_in) begin
            chk(ev_wr_cnt[mon_ev] >= 2 || ev_done[mon_ev], "R2", "early start, words written",
                64'(ev_wr_cnt[mon_ev]), 64'd2);
            if (ev_len[mon_ev] == 1)
              chk(ev_wr_cnt[mon_ev+1] == 0, "R4", "short event held for next event",
                  64'(ev_wr_cnt[mon_ev+1]), 64'd0);
            mon_in = 1;
            gaps = 0;
          end
          if (rd_last) begin
            if (!ev_gap_ok[mon_ev])
              chk(gaps == 0, "R3", "gap cycles in stream", 64'(gaps), 64'd0);
            mon_ev++;
            mon_in = 0;
          end
        end
      end else if (mon_in) begin
        gaps++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!finished) begin
      chk(1'b0, "WDOG", "watchdog expired", 64'd1, 64'd0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (6) @(posedge wr_clk);
    #1;
    chk(rd_valid == 1'b0, "R8", "rd_valid in reset", 64'(rd_valid), 64'd0);
    chk(underrun == 1'b0, "R8", "underrun in reset", 64'(underrun), 64'd0);
    chk(overflow == 1'b0, "R8", "overflow in reset", 64'(overflow), 64'd0);
    @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (5) @(negedge wr_clk);

    send_event(4, 0, 0, 3, 0);
    send_event(1, 0, 0, 20, 0);   // R4 isolated single word
    send_event(8, 25, 0, 3, 0);   // R2 pause after first word
    for (int k = 0; k < 4; k++) send_event(3, 0, 0, 3, 0);
    send_event(500, 0, 0, 3, 0);  // R3 longest event
    send_event(2, 0, 0, 3, 0);
    drain();
    chk(underrun == 1'b0, "R6", "underrun after clean traffic", 64'(underrun), 64'd0);
    chk(overflow == 1'b0, "R7", "overflow after clean traffic", 64'(overflow), 64'd0);

    // R7: halt reader, fill all entries, offer one more word
    @(negedge rd_clk);
    rd_run = 1'b0;
    send_event(1024, 0, 0, 0, 0);
    @(negedge wr_clk);
    wr_valid = 1'b1;
    wr_data  = 32'hDEAD_BEEF;
    wr_last  = 1'b1;
    @(negedge wr_clk);
    wr_valid = 1'b0;
    wr_last  = 1'b0;
    repeat (5) @(negedge wr_clk);
    rd_run = 1'b1;
    drain();
    chk(overflow == 1'b1, "R7", "overflow after dropped word", 64'(overflow), 64'd1);
    chk(underrun == 1'b0, "R6", "underrun after full drain", 64'(underrun), 64'd0);

    // R6: writer stalls before the final word
    send_event(4, 0, 40, 3, 1);
    drain();
    chk(underrun == 1'b1, "R6", "underrun after stalled event", 64'(underrun), 64'd1);
    chk(overflow == 1'b1, "R7", "overflow still held", 64'(overflow), 64'd1);
    chk(exp_q.size() == 0, "R1", "words left undelivered", 64'(exp_q.size()), 64'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule